// File: doc/BRIEF.md
# Clamped PI Loop Filter

This block is the loop filter of a carrier recovery loop. On every clock it takes one signed phase-error sample and produces a signed 18-bit frequency correction word. The word is the sum of a proportional term and an integral term. The proportional term is the error times a runtime gain. The integral term is a running accumulation of the error times a second runtime gain. Both products are scaled down by fixed arithmetic right shifts. The gains and the limit are ordinary data inputs, so a controller can retune the loop between samples.

The limit input sets the largest correction magnitude the loop may ever ask for. The output is clamped symmetrically to plus or minus that magnitude. The integrator state is clamped to the same window, so a long saturated stretch leaves no stored excess to unwind. Every multiply and sum saturates instead of wrapping, so a large error never flips the sign of the correction.

Top module: `carrier_pi_filter`

## Requirements
- R1: While the active-low asynchronous reset is low, `freq_out` is 0 and the integrator state is 0. After release, an all-zero input stream keeps the output at 0.
- R2: Each clock accepts one sample. The inputs presented before rising edge N set `freq_out` from rising edge N+1 onward, which is two registers later. With `gain_i` = 0 the output is clamp(floor(err*gain_p / 2^P_SHIFT)).
- R3: Both scaled products round toward negative infinity. With the default shift of 12, an error of -1 and a gain of 1 give -1, and an error of 1 and a gain of 1 give 0.
- R4: `|freq_out|` never exceeds the magnitude of the limit that was sampled with the same input set.
- R5: A negative `lim_in` acts as its absolute value. The most negative code, -131072, acts as +131071.
- R6: Each clock, the integrator adds floor(err*gain_i / 2^I_SHIFT) and clamps the result to ±|limit|. The output is then clamp(proportional + integrator). Because of this, a reversal of the error moves the output away from the rail on the very next result.
- R7: Products and sums too large for the output saturate in the direction of their true sign and never wrap. A maximum positive error with a maximum positive gain yields +|limit|.
- R8: A new `gain_p`, `gain_i` or `lim_in` takes effect for the sample presented in the same cycle. No other sample is affected by the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_in | input | 16 | Signed phase error sample |
| gain_p | input | 18 | Signed proportional gain, unit = 2^P_SHIFT |
| gain_i | input | 18 | Signed integral gain, unit = 2^I_SHIFT |
| lim_in | input | 18 | Signed limit; its magnitude bounds the output |
| freq_out | output | 18 | Signed clamped frequency correction word |

## Verification
The assertions assume only that the clock runs and that the inputs are settled at each rising edge. Every code of `err_in`, the gains and `lim_in` is legal, including the most negative ones, so the bounds on the output and on the integrator must hold for any stimulus. To keep every input stable at the edge, the stimulus changes the inputs only at falling edges. It also covers the extreme codes of all four inputs, negative limits, and gain changes from one sample to the next.

// File: rtl/pi_filt_pkg.sv
package pi_filt_pkg;
   // Index of each product lane in the shared multiplier generate loop
   typedef enum int {
      LANE_PROP  = 0,
      LANE_INTEG = 1
   } lane_e;

   localparam int NUM_LANES = 2;
endpackage

// File: rtl/pi_scaled_product.sv
module pi_scaled_product #(
   parameter int A_W   = 16,
   parameter int B_W   = 18,
   parameter int SHIFT = 12,
   parameter int RES_W = 19
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [A_W-1:0]   a,
   input  logic signed [B_W-1:0]   b,
   output logic signed [RES_W-1:0] res
);
   localparam int PW = A_W + B_W;
   localparam logic signed [PW-1:0] RMAX =
      $signed({{(PW-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}});
   localparam logic signed [PW-1:0] RMIN = -RMAX;

   if (SHIFT < 0 || SHIFT >= PW) begin : g_bad_shift
      $error("pi_scaled_product: SHIFT out of range");
   end
   if (RES_W < 2 || RES_W > PW) begin : g_bad_width
      $error("pi_scaled_product: RES_W out of range");
   end

   logic signed [PW-1:0] full;
   logic signed [PW-1:0] scaled;

   assign full = a * b;

   if (SHIFT == 0) begin : g_noshift
      assign scaled = full;
   end else begin : g_shift
      // arithmetic shift: floor toward negative infinity
      assign scaled = full >>> SHIFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res <= '0;
      end else if (scaled > RMAX) begin
         res <= RMAX[RES_W-1:0];
      end else if (scaled < RMIN) begin
         res <= RMIN[RES_W-1:0];
      end else begin
         res <= scaled[RES_W-1:0];
      end
   end
endmodule

// File: rtl/pi_abs_limit.sv
module pi_abs_limit #(
   parameter int W = 18
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] lim_in,
   output logic signed [W-1:0] lim_abs
);
   localparam logic signed [W-1:0] MOST_NEG = $signed({1'b1, {(W-1){1'b0}}});
   localparam logic signed [W-1:0] MOST_POS = $signed({1'b0, {(W-1){1'b1}}});

   if (W < 2) begin : g_bad_w
      $error("pi_abs_limit: W must be at least 2");
   end

   logic signed [W-1:0] mag;

   always_comb begin
      if (lim_in == MOST_NEG) begin
         mag = MOST_POS;
      end else if (lim_in < 0) begin
         mag = -lim_in;
      end else begin
         mag = lim_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_abs <= '0;
      end else begin
         lim_abs <= mag;
      end
   end
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator #(
   parameter int OUT_W = 18,
   parameter int INC_W = 19
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [INC_W-1:0] inc,
   input  logic signed [OUT_W-1:0] lim,
   output logic signed [OUT_W-1:0] integ_next,
   output logic signed [OUT_W-1:0] integ_q
);
   localparam int SW = ((INC_W > OUT_W) ? INC_W : OUT_W) + 1;

   if (INC_W < OUT_W) begin : g_bad_inc
      $error("pi_integrator: INC_W narrower than OUT_W");
   end

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] hi;
   logic signed [SW-1:0] lo;

   assign sum = SW'(inc) + SW'(integ_q);
   assign hi  = SW'(lim);
   assign lo  = -hi;

   always_comb begin
      if (sum > hi) begin
         integ_next = hi[OUT_W-1:0];
      end else if (sum < lo) begin
         integ_next = lo[OUT_W-1:0];
      end else begin
         integ_next = sum[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ_q <= '0;
      end else begin
         integ_q <= integ_next;
      end
   end
endmodule

// File: rtl/carrier_pi_filter.sv
module carrier_pi_filter
   import pi_filt_pkg::*;
#(
   parameter int ERR_W   = 16,
   parameter int GAIN_W  = 18,
   parameter int OUT_W   = 18,
   parameter int P_SHIFT = 12,
   parameter int I_SHIFT = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [ERR_W-1:0]  err_in,
   input  logic signed [GAIN_W-1:0] gain_p,
   input  logic signed [GAIN_W-1:0] gain_i,
   input  logic signed [OUT_W-1:0]  lim_in,
   output logic signed [OUT_W-1:0]  freq_out
);
   // products saturate at twice the output range so the final clamp is exact
   localparam int PROD_W = OUT_W + 1;
   localparam int SUM_W  = OUT_W + 2;

   if (ERR_W < 2 || GAIN_W < 2 || OUT_W < 2) begin : g_bad_widths
      $error("carrier_pi_filter: widths must be at least 2");
   end
   if (PROD_W > ERR_W + GAIN_W) begin : g_bad_prod
      $error("carrier_pi_filter: OUT_W too wide for the product");
   end

   logic signed [GAIN_W-1:0] lane_gain [NUM_LANES];
   logic signed [PROD_W-1:0] lane_prod [NUM_LANES];

   assign lane_gain[LANE_PROP]  = gain_p;
   assign lane_gain[LANE_INTEG] = gain_i;

   // stage 1: scaled products and limit magnitude
   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam int SH = (g == int'(LANE_PROP)) ? P_SHIFT : I_SHIFT;
      pi_scaled_product #(
         .A_W  (ERR_W),
         .B_W  (GAIN_W),
         .SHIFT(SH),
         .RES_W(PROD_W)
      ) u_mul (
         .clk  (clk),
         .rst_n(rst_n),
         .a    (err_in),
         .b    (lane_gain[g]),
         .res  (lane_prod[g])
      );
   end

   logic signed [OUT_W-1:0] lim_q;

   pi_abs_limit #(.W(OUT_W)) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .lim_in (lim_in),
      .lim_abs(lim_q)
   );

   // stage 2: integrator update and clamped sum
   logic signed [OUT_W-1:0] integ_next;
   logic signed [OUT_W-1:0] integ_q;

   pi_integrator #(.OUT_W(OUT_W), .INC_W(PROD_W)) u_int (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (lane_prod[LANE_INTEG]),
      .lim       (lim_q),
      .integ_next(integ_next),
      .integ_q   (integ_q)
   );

   logic signed [SUM_W-1:0] total;
   logic signed [SUM_W-1:0] hi;
   logic signed [SUM_W-1:0] lo;
   logic signed [OUT_W-1:0] freq_d;

   assign total = SUM_W'(lane_prod[LANE_PROP]) + SUM_W'(integ_next);
   assign hi    = SUM_W'(lim_q);
   assign lo    = -hi;

   always_comb begin
      if (total > hi) begin
         freq_d = hi[OUT_W-1:0];
      end else if (total < lo) begin
         freq_d = lo[OUT_W-1:0];
      end else begin
         freq_d = total[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_out <= '0;
      end else begin
         freq_out <= freq_d;
      end
   end
endmodule

// File: rtl/pi_filter_checker.sv
module pi_filter_checker #(
   parameter int OUT_W = 18
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [OUT_W-1:0] freq_out,
   input logic signed [OUT_W-1:0] lim_q,
   input logic signed [OUT_W-1:0] integ_q
);
   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_clear_chk: assert (freq_out == '0 && integ_q == '0)
            else $error("R1: state not cleared in reset");
      end
   end

   // R4
   freq_in_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_out <= $past(lim_q)) && (freq_out >= -$past(lim_q)))
      else $error("R4: output outside limit");

   // R5
   lim_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lim_q >= 0)
      else $error("R5: limit magnitude negative");

   // R6
   integ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (integ_q <= $past(lim_q)) && (integ_q >= -$past(lim_q)))
      else $error("R6: integrator outside limit");
endmodule

bind carrier_pi_filter pi_filter_checker #(.OUT_W(OUT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .freq_out(freq_out),
   .lim_q   (lim_q),
   .integ_q (integ_q)
);

// File: tb/sim_carrier_pi_filter.sv
module sim_carrier_pi_filter;
   localparam int PSH = 12;
   localparam int ISH = 12;

   typedef struct {
      longint due;
      longint exp;
      string  tag;
   } item_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] err_in = '0;
   logic signed [17:0] gain_p = '0;
   logic signed [17:0] gain_i = '0;
   logic signed [17:0] lim_in = '0;
   logic signed [17:0] freq_out;

   int     checks = 0;
   int     fails = 0;
   longint cyc = 0;
   bit     done = 1'b0;
   item_t  sb[$];
   longint m_integ = 0;

   always #4 clk = ~clk;

   carrier_pi_filter u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_in  (err_in),
      .gain_p  (gain_p),
      .gain_i  (gain_i),
      .lim_in  (lim_in),
      .freq_out(freq_out)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint clampv(longint v, longint l);
      if (v > l) return l;
      if (v < -l) return -l;
      return v;
   endfunction

   // driver: one sample per call, consecutive calls are consecutive cycles
   task automatic send(longint e, longint kp, longint ki, longint lim, string tag);
      longint la, p, i, o;
      item_t it;
      @(negedge clk);
      err_in = 16'(e);
      gain_p = 18'(kp);
      gain_i = 18'(ki);
      lim_in = 18'(lim);
      la = (lim == -131072) ? 131071 : ((lim < 0) ? -lim : lim);
      p = (e * kp) >>> PSH;
      i = (e * ki) >>> ISH;
      m_integ = clampv(m_integ + i, la);
      o = clampv(p + m_integ, la);
      it.due = cyc + 2;
      it.exp = o;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compares results as they leave the pipeline
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].due == cyc) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (longint'(freq_out) != it.exp) begin
            fails++;
            $display("FAIL %s: freq_out=%0d expected=%0d", it.tag, freq_out, it.exp);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
   end

   initial begin
      // R1: outputs cleared while reset is held
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (freq_out !== 18'sd0) begin
            fails++;
            $display("FAIL R1: freq_out=%0d expected=0", freq_out);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;
      send(0, 0, 0, 0, "R1");
      send(0, 0, 0, 1000, "R1");

      // R2: unity proportional gain, various error patterns
      send(1234, 4096, 0, 100000, "R2");
      send(-777, 4096, 0, 100000, "R2");
      send(32767, 4096, 0, 100000, "R2");
      send(100, 8192, 0, 100000, "R2");
      send(-5, 40960, 0, 100000, "R2");

      // R3: floor rounding of negative products
      send(-1, 1, 0, 1000, "R3");
      send(1, 1, 0, 1000, "R3");
      send(-4097, 1, 0, 1000, "R3");
      send(-3, -4096, 0, 1000, "R3");

      // R4: output clamp
      send(20000, 4096, 0, 500, "R4");
      send(-20000, 4096, 0, 500, "R4");
      send(499, 4096, 0, 500, "R4");

      // R5: negative limits act as magnitude
      send(20000, 4096, 0, -500, "R5");
      send(-20000, 4096, 0, -500, "R5");
      send(32767, 131071, 0, -131072, "R5");

      // R6: integrator accumulates, is held at the limit, recovers at once
      for (int k = 0; k < 8; k++) send(1000, 0, 4096, 5000, "R6");
      send(-1000, 0, 4096, 5000, "R6");
      send(-1000, 0, 4096, 5000, "R6");
      for (int k = 0; k < 14; k++) send(-1000, 4096, 4096, 5000, "R6");
      send(2500, 4096, 4096, 5000, "R6");

      // R7: saturation instead of wrap
      send(32767, 131071, 0, 131071, "R7");
      send(-32768, 131071, 0, 131071, "R7");
      send(-32768, -131072, 0, 131071, "R7");
      send(32767, 0, 131071, 131071, "R7");
      send(32767, 0, 131071, 131071, "R7");

      // R8: parameters change from one sample to the next
      send(1000, 4096, 0, 100000, "R8");
      send(1000, 8192, 0, 100000, "R8");
      send(1000, 8192, 2048, 700, "R8");
      send(1000, 0, -4096, -100000, "R8");
      send(1000, -4096, 0, 300, "R8");

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule